// File: doc/BRIEF.md
# Serial EEPROM Access Controller

This block sits behind the byte-level front end of a two-wire serial slave and serves the memory function of a small maintenance device. The front end reports bus START and STOP events, each received byte, and each request for a byte to transmit. The controller decodes the address byte and acknowledges it. It runs memory writes and reads against a 256 x 8 array that is modelled as a register array.

A write transaction carries a word address and then data bytes. The data bytes go into a 16-entry page buffer with one valid flag per byte. A STOP that follows buffered data starts a self-timed programming cycle of `WRITE_CYCLES` system clocks. When that cycle ends, only the buffered bytes marked valid are copied into the array. Reads come from an internal address counter, which always points one past the last location accessed. This supports current-address reads, random reads (a dummy write followed by a repeated START) and sequential reads. While programming is in progress the memory function refuses its address, but the port function of the device keeps working.

Top module: `eeprom_access`

## Requirements
- R1: An address byte has bit 7 = 1 for memory, bits 6:1 equal to `devAddr`, and bit 0 = R/W (1 = read). When such a byte matches and the block is not busy, `ackOut` = 1 in the cycle after `rxValid`, together with an `ackValid` pulse. A byte whose bits 6:1 differ from `devAddr` gets `ackOut` = 0.
- R2: A port address byte (bit 7 = 0, bits 6:1 = `devAddr`) is acknowledged and pulses `portHit`, whether or not the block is busy.
- R3: While `busy` is high, a memory address byte is not acknowledged.
- R4: In a write, the first byte after the address is the word address and the following bytes are data. Each is acknowledged, and the data lands at consecutive locations once programming completes.
- R5: During a write, only the low four address bits advance. A 17th data byte wraps to the starting location and overwrites the earlier byte.
- R6: `busy` rises in the cycle after a STOP that ends a write carrying data, and stays high for exactly `WRITE_CYCLES` cycles.
- R7: A write that ends with STOP directly after the word address does not raise `busy`. It only loads the address counter.
- R8: After an access to location n, a current-address read returns location n+1.
- R9: Each `txReq` during a read places the byte at the counter on `txByte` in the following cycle and advances the counter. The counter rolls over from 255 to 0.
- R10: A START and a port transaction during programming do not disturb the pending page, which is still committed in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| devAddr | input | 6 | Device address strap |
| startSeen | input | 1 | One-cycle pulse on START or repeated START |
| stopSeen | input | 1 | One-cycle pulse on STOP |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| txReq | input | 1 | Front end requests the next read byte |
| ackValid | output | 1 | Acknowledge decision valid |
| ackOut | output | 1 | 1 = acknowledge the last received byte |
| portHit | output | 1 | Port address accepted |
| txByte | output | 8 | Byte to transmit |
| busy | output | 1 | Programming cycle in progress |

## Verification
`ackValid`, `ackOut` and `portHit` are due one clock after the `rxValid` cycle. `txByte` is due one clock after `txReq`, and `busy` rises one clock after `stopSeen`. The bench drives every strobe for a single cycle from a falling edge and reads the results at the next falling edge, which lies exactly one register stage later. It measures the length of the programming window by counting falling edges while `busy` is high, and compares that count with `WRITE_CYCLES`. Array contents are checked afterwards through reads, against a model that applies the same page-wrap and rollover rules.

// File: rtl/eeacc_pkg.sv
package eeacc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WADDR, ST_WDATA, ST_READ
  } eeState_t;

  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic readNext;
    logic clearBuf;
    logic commit;
  } eeStrobe_t;
endpackage

// File: rtl/eeacc_ctrl.sv
module eeacc_ctrl
  import eeacc_pkg::*;
#(
  parameter int WRITE_CYCLES = 50,
  parameter int DEV_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEV_W-1:0]  devAddr,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txReq,
  input  logic              anyValid,
  output eeStrobe_t         strobe,
  output logic              ackValid,
  output logic              ackOut,
  output logic              portHit,
  output logic              busy
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  eeState_t state;
  logic [CW-1:0] cnt;
  logic idMatch, memMatch, portMatch;

  assign idMatch   = (rxByte[DEV_W:1] == devAddr);
  assign memMatch  = rxByte[DATA_W-1] && idMatch;
  assign portMatch = !rxByte[DATA_W-1] && idMatch;

  always_comb begin
    strobe = '0;
    strobe.loadAddr  = rxValid && (state == ST_WADDR);
    strobe.storeByte = rxValid && (state == ST_WDATA);
    strobe.readNext  = txReq && (state == ST_READ);
    strobe.clearBuf  = startSeen && !busy;
    strobe.commit    = busy && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackValid <= 1'b0;
      ackOut   <= 1'b0;
      portHit  <= 1'b0;
    end else begin
      ackValid <= rxValid;
      portHit  <= 1'b0;
      if (startSeen) begin
        state <= ST_ADDR;
      end else if (stopSeen) begin
        state <= ST_IDLE;
      end else if (rxValid) begin
        unique case (state)
          ST_ADDR: begin
            ackOut  <= (memMatch && !busy) || portMatch;
            portHit <= portMatch;
            if (memMatch && !busy)
              state <= rxByte[0] ? ST_READ : ST_WADDR;
            else
              state <= ST_IDLE;
          end
          ST_WADDR: begin
            ackOut <= 1'b1;
            state  <= ST_WDATA;
          end
          ST_WDATA: ackOut <= 1'b1;
          default:  ackOut <= 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (stopSeen && state == ST_WDATA && anyValid) begin
      busy <= 1'b1;
      cnt  <= CW'(WRITE_CYCLES - 1);
    end
  end
endmodule

// File: rtl/eeacc_data.sv
module eeacc_data
  import eeacc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeStrobe_t         strobe,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] txByte,
  output logic              anyValid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] pageBuf [PAGE];
  logic [PAGE-1:0]   pageVld;
  logic [ADDR_W-1:0] addrCnt;

  assign anyValid = |pageVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
      txByte  <= '0;
    end else if (strobe.loadAddr) begin
      addrCnt <= rxByte[ADDR_W-1:0];
    end else if (strobe.storeByte) begin
      addrCnt[PAGE_W-1:0] <= addrCnt[PAGE_W-1:0] + 1'b1;
    end else if (strobe.readNext) begin
      txByte  <= memArr[addrCnt];
      addrCnt <= addrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageVld <= '0;
    end else if (strobe.commit || strobe.clearBuf) begin
      pageVld <= '0;
    end else if (strobe.storeByte) begin
      pageVld[addrCnt[PAGE_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeByte) pageBuf[addrCnt[PAGE_W-1:0]] <= rxByte;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [PAGE_W-1:0] SLOT = PAGE_W'(g % PAGE);
    localparam logic [ADDR_W-PAGE_W-1:0] PG = (ADDR_W-PAGE_W)'(g / PAGE);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        memArr[g] <= '0;
      else if (strobe.commit && pageVld[SLOT] && addrCnt[ADDR_W-1:PAGE_W] == PG)
        memArr[g] <= pageBuf[SLOT];
    end
  end
endmodule

// File: rtl/eeprom_access.sv
module eeprom_access
  import eeacc_pkg::*;
#(
  parameter int WRITE_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] devAddr,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       txReq,
  output logic       ackValid,
  output logic       ackOut,
  output logic       portHit,
  output logic [7:0] txByte,
  output logic       busy
);
  eeStrobe_t strobe;
  logic anyValid;

  eeacc_ctrl #(.WRITE_CYCLES(WRITE_CYCLES), .DEV_W(6), .DATA_W(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .startSeen(startSeen),
    .stopSeen(stopSeen), .rxValid(rxValid), .rxByte(rxByte), .txReq(txReq),
    .anyValid(anyValid), .strobe(strobe), .ackValid(ackValid),
    .ackOut(ackOut), .portHit(portHit), .busy(busy)
  );

  eeacc_data #(.ADDR_W(8), .PAGE_W(4), .DATA_W(8)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .txByte(txByte), .anyValid(anyValid)
  );
endmodule

// File: rtl/eeprom_access_chk.sv
module eeprom_access_chk #(
  parameter int WRITE_CYCLES = 50
) (
  input logic       clk,
  input logic       rstN,
  input logic       stopSeen,
  input logic       rxValid,
  input logic [7:0] rxByte,
  input logic       txReq,
  input logic       ackValid,
  input logic       ackOut,
  input logic       portHit,
  input logic [7:0] txByte,
  input logic       busy
);
  logic [31:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= '0;
  end

  // R1
  ack_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> ackValid);

  // R1
  ack_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !ackValid);

  // R3
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && busy && rxByte[7]) |=> !ackOut);

  // R2
  port_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    portHit |-> (ackOut && ackValid));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == WRITE_CYCLES));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txReq |=> $stable(txByte));
endmodule

bind eeprom_access eeprom_access_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .stopSeen(stopSeen), .rxValid(rxValid),
  .rxByte(rxByte), .txReq(txReq), .ackValid(ackValid), .ackOut(ackOut),
  .portHit(portHit), .txByte(txByte), .busy(busy)
);

// File: tb/sim_eeprom_access.sv
module sim_eeprom_access;
  localparam int WCYC = 50;
  localparam logic [5:0] DEV = 6'h2B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] devAddr = DEV;
  logic startSeen = 0, stopSeen = 0, rxValid = 0, txReq = 0;
  logic [7:0] rxByte = '0;
  logic ackValid, ackOut, portHit, busy;
  logic [7:0] txByte;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [7:0] model [256];
  logic [7:0] modelCnt;

  always #10 clk = ~clk;

  eeprom_access #(.WRITE_CYCLES(WCYC)) u0 (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .startSeen(startSeen),
    .stopSeen(stopSeen), .rxValid(rxValid), .rxByte(rxByte), .txReq(txReq),
    .ackValid(ackValid), .ackOut(ackOut), .portHit(portHit),
    .txByte(txByte), .busy(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: act=%0d expected below 150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memAddrByte(input logic rd);
    return {1'b1, DEV, rd};
  endfunction

  task automatic pulseStart();
    @(negedge clk) startSeen = 1;
    @(negedge clk) startSeen = 0;
  endtask

  task automatic pulseStop();
    @(negedge clk) stopSeen = 1;
    @(negedge clk) stopSeen = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    @(negedge clk) begin rxByte = b; rxValid = 1; end
    @(negedge clk) rxValid = 0;
    ack = ackOut;
  endtask

  task automatic getByte(output logic [7:0] b);
    @(negedge clk) txReq = 1;
    @(negedge clk) txReq = 0;
    b = txByte;
  endtask

  task automatic waitIdle(output int len);
    len = 0;
    while (busy) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic memWrite(input logic [7:0] wa, input int n, input int seed);
    logic ack;
    logic [7:0] d;
    int len;
    pulseStart();
    sendByte(memAddrByte(1'b0), ack);
    check(ack, "R1 mem write address ack", ack, 1);
    sendByte(wa, ack);
    check(ack, "R4 word address ack", ack, 1);
    modelCnt = wa;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom) ^ 8'(seed);
      sendByte(d, ack);
      check(ack, "R4 data ack", ack, 1);
      model[modelCnt] = d;
      modelCnt[3:0] = modelCnt[3:0] + 1'b1;
    end
    pulseStop();
    if (n > 0) begin
      check(busy, "R6 busy after stop", busy, 1);
      waitIdle(len);
      check(len == WCYC, "R6 busy length", len, WCYC);
    end else begin
      check(!busy, "R7 dummy write no busy", busy, 0);
    end
  endtask

  task automatic memRead(input logic useAddr, input logic [7:0] ra, input int n, input string req);
    logic ack;
    logic [7:0] b;
    pulseStart();
    if (useAddr) begin
      sendByte(memAddrByte(1'b0), ack);
      sendByte(ra, ack);
      modelCnt = ra;
      pulseStart();
    end
    sendByte(memAddrByte(1'b1), ack);
    check(ack, "R1 mem read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      getByte(b);
      check(b == model[modelCnt], req, b, model[modelCnt]);
      modelCnt = modelCnt + 1'b1;
    end
    pulseStop();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int len;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) model[i] = '0;
    modelCnt = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!busy && !ackValid && !portHit, "R6 reset idle", busy, 0);
    check(txByte == 8'h00, "R9 reset txByte", txByte, 0);

    // R1 mismatched device address
    pulseStart();
    sendByte({1'b1, DEV ^ 6'h01, 1'b0}, ack);
    check(!ack, "R1 wrong address nack", ack, 0);
    pulseStop();

    // R4 byte write then read back
    memWrite(8'h37, 1, 5);
    memRead(1'b1, 8'h37, 1, "R4 byte write readback");

    // R8 current address read follows previous access
    memWrite(8'h50, 1, 9);
    memRead(1'b0, 8'h00, 1, "R8 current address read");

    // R5 page wrap with 18 data bytes from mid page
    memWrite(8'h8A, 18, 3);
    memRead(1'b1, 8'h80, 16, "R5 page wrap readback");

    // R9 sequential read rollover 255 -> 0
    memWrite(8'hFE, 2, 7);
    memWrite(8'h00, 1, 11);
    memRead(1'b1, 8'hFE, 4, "R9 sequential rollover");

    // R7 dummy write: no busy, counter loaded
    memWrite(8'h8C, 0, 0);
    memRead(1'b0, 8'h00, 2, "R7 dummy write loads counter");

    // R3, R2, R10 accesses during programming
    pulseStart();
    sendByte(memAddrByte(1'b0), ack);
    sendByte(8'h20, ack);
    modelCnt = 8'h20;
    for (int i = 0; i < 4; i++) begin
      b = 8'hA0 + 8'(i);
      sendByte(b, ack);
      model[modelCnt] = b;
      modelCnt[3:0] = modelCnt[3:0] + 1'b1;
    end
    pulseStop();
    pulseStart();
    sendByte(memAddrByte(1'b1), ack);
    check(!ack, "R3 memory nack while busy", ack, 0);
    pulseStart();
    sendByte({1'b0, DEV, 1'b0}, ack);
    check(ack && portHit, "R2 port ack while busy", {ack, portHit}, 3);
    pulseStop();
    waitIdle(len);
    memRead(1'b1, 8'h20, 4, "R10 page survives port access");

    // R2 port ack when idle
    pulseStart();
    sendByte({1'b0, DEV, 1'b1}, ack);
    check(ack && portHit, "R2 port ack idle", {ack, portHit}, 3);
    pulseStop();

    // random mix
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(1, 0) == 1)
        memWrite(8'($urandom), $urandom_range(20, 1), k);
      else
        memRead(1'b1, 8'($urandom), $urandom_range(6, 1), "R9 random read");
    end
    memRead(1'b0, 8'h00, 3, "R8 random current read");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule